// File: doc/BRIEF.md
# Host Video-Memory Access Port

This block is the processor-side access path of a video controller. The host talks to it through two byte-wide ports selected by `cpu_sel`. Bytes written to the control port arrive in pairs. The first byte is parked in a latch. The second byte then either writes a numbered register or loads the video-memory pointer. Bytes moved through the data port never touch memory directly. They pass through a single read-ahead byte buffer, and each one leaves behind one pending memory operation.

A pending operation waits for a memory slot offered by the display timing logic. The slot must be granted at a column no earlier than a programmable minimum. When the operation runs, it uses the current pointer, and the pointer then advances by one. When colour RAM is selected, pending writes go to a 32-entry palette instead of memory. Each 6-bit colour is widened to 24-bit RGB on the way in. Blue uses a non-linear scale.

Top module: `vram_host_port`

## Requirements
- R1: After synchronous active-low reset the following hold. The next control byte is treated as the first of a pair. No access is pending, so `mem_req` is 0. The pointer (`mem_addr`) is 0. The read-ahead buffer is 0. `cpu_rdata` is 0. `reg_we` is 0.
- R2: A second control byte with bit 7 set causes a one-cycle pulse on `reg_we` in the cycle after the byte. In that cycle `reg_idx` equals bits 3:0 of the second byte and `reg_val` equals the first byte. The pointer does not change.
- R3: A second control byte with bit 7 clear loads the pointer. The pointer's low 8 bits come from the first byte and its bits 13:8 come from bits 5:0 of the second byte. If bit 6 is clear, a read becomes pending. If bit 6 is set, any pending access is cancelled.
- R4: A data-port write puts the CPU byte into the buffer and makes a write pending. When the write executes, `mem_we` is high in the slot cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to the buffer. After that the pointer is incremented and `mem_req` drops.
- R5: A pending access executes only in a cycle where `slot_grant` is 1 and `slot_col` is greater than or equal to `min_col`. A grant at a lower column raises no strobe and leaves the access pending.
- R6: A data-port read presents the current buffer on `cpu_rdata` in the next cycle and makes a read pending. An executing read raises `mem_re`, loads the buffer from `mem_rdata` in the same cycle, and increments the pointer.
- R7: A data-port access or a control-port read resets the pairing, so the next control byte is a first byte.
- R8: With `pal_sel` high, an executing write stores the buffer into palette entry `pointer[4:0]` and does not raise `mem_we`. The pointer still increments.
- R9: A palette colour c is stored as `{R,G,B}`, with R in bits 23:16. R is c[1:0]×85 and G is c[3:2]×85. B is chosen from c[5:4] through the table 0, 104, 170, 255.
- R10: The pointer is 14 bits wide and wraps from 0x3FFF to 0x0000.
- R11: Only one access can be pending. A new data-port access replaces the one that has not yet executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | 0 = data port, 1 = control port |
| cpu_wr | input | 1 | Write strobe, one cycle per byte |
| cpu_rd | input | 1 | Read strobe, one cycle per byte |
| cpu_wdata | input | 8 | Byte from the host |
| cpu_rdata | output | 8 | Byte to the host, registered |
| pal_sel | input | 1 | Routes executed writes to the palette |
| reg_we | output | 1 | Register write pulse |
| reg_idx | output | 4 | Register number |
| reg_val | output | 8 | Register value |
| mem_req | output | 1 | An access is pending |
| slot_grant | input | 1 | A memory slot is offered this cycle |
| slot_col | input | 9 | Column of the offered slot |
| min_col | input | 9 | Earliest column at which an access may run |
| mem_addr | output | 14 | Memory address (the pointer) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| pal_rd_idx | input | 5 | Palette lookup index |
| pal_rd_rgb | output | 24 | Palette lookup colour |

## Verification
Each of the 64 colour codes is written into the palette, so every entry is written twice, and every result is compared with arithmetic scaling. A design that used the linear scale for blue, or swapped channel fields, would fail there.

The tests grant slots below the minimum column and check that nothing executes. They also run the pointer across the 0x3FFF boundary. A design that fires early, or one that carries into a fifteenth bit, would show the wrong strobe or address.

A stray first control byte is followed by a data read. A design that failed to reset the pairing would then decode the next pair shifted by one byte. Two data writes are issued back to back before a slot. A design with a deeper queue, or one that kept the old byte, would write twice or write stale data.

// File: rtl/vhp_pkg.sv
// Shared types and colour scaling for the host video-memory access port.
// Assumes 2-bit colour channels packed as {blue, green, red} in a 6-bit code.
package vhp_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Linear 2-bit to 8-bit widening for red and green
    function automatic logic [7:0] widen_lin(input logic [1:0] v);
        return {v, v, v, v};
    endfunction

    // Non-linear 2-bit to 8-bit widening for blue
    function automatic logic [7:0] widen_blue(input logic [1:0] v);
        case (v)
            2'd0:    return 8'd0;
            2'd1:    return 8'd104;
            2'd2:    return 8'd170;
            default: return 8'd255;
        endcase
    endfunction

    // Widen a 6-bit colour code to packed 24-bit {R,G,B}
    function automatic logic [23:0] widen_colour(input logic [5:0] c);
        return {widen_lin(c[1:0]), widen_lin(c[3:2]), widen_blue(c[5:4])};
    endfunction

endpackage

// File: rtl/vhp_ctrl_seq.sv
// Control-port byte pairing.
// The first byte is latched. The second byte either writes a register
// (bit 7 set) or loads the pointer. Assumes ctrl_wr and phase_clr are
// never high together.
module vhp_ctrl_seq #(
    parameter int AW = 14,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          phase_clr,
    input  logic [7:0]    din,
    output logic          reg_we,
    output logic [RW-1:0] reg_idx,
    output logic [7:0]    reg_val,
    output logic          addr_ld,
    output logic [AW-1:0] addr_val,
    output logic          addr_rdq
);
    localparam int HI_W = AW - 8;

    logic       second_pending;
    logic [7:0] low_latch;
    logic       is_second;

    assign is_second = ctrl_wr && second_pending;
    assign addr_ld   = is_second && !din[7];
    assign addr_val  = {din[HI_W-1:0], low_latch};
    assign addr_rdq  = !din[6];

    // Track which byte of a pair comes next
    always_ff @(posedge clk) begin
        if (!rst_n)         second_pending <= 1'b0;
        else if (ctrl_wr)   second_pending <= !second_pending;
        else if (phase_clr) second_pending <= 1'b0;
    end

    // Hold the first byte of a pair
    always_ff @(posedge clk) begin
        if (!rst_n)                         low_latch <= 8'h00;
        else if (ctrl_wr && !second_pending) low_latch <= din;
    end

    // Emit the register write for a second byte with bit 7 set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we  <= 1'b0;
            reg_idx <= '0;
            reg_val <= 8'h00;
        end else begin
            reg_we <= is_second && din[7];
            if (is_second && din[7]) begin
                reg_idx <= din[RW-1:0];
                reg_val <= low_latch;
            end
        end
    end

    // R7
    phase_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_clr && !ctrl_wr) |=> !second_pending);

    // R2
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

endmodule

// File: rtl/vhp_access_engine.sv
// Pending-access engine.
// Holds the read-ahead buffer, the pointer and a single pending access.
// The access runs on a granted slot at or after the minimum column.
// Assumes memory read data is valid in the same cycle as the address.
module vhp_access_engine
    import vhp_pkg::*;
#(
    parameter int AW    = 14,
    parameter int COL_W = 9,
    parameter int PI_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [7:0]       din,
    input  logic             addr_ld,
    input  logic [AW-1:0]    addr_val,
    input  logic             addr_rdq,
    input  logic             slot_grant,
    input  logic [COL_W-1:0] slot_col,
    input  logic [COL_W-1:0] min_col,
    input  logic             pal_sel,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       buf_q,
    output logic [AW-1:0]    ptr_q,
    output logic             busy,
    output logic             mem_we,
    output logic             mem_re,
    output logic             pal_we,
    output logic [PI_W-1:0]  pal_idx
);
    acc_kind_t pend_q;
    logic      exec;

    assign busy    = (pend_q != ACC_NONE);
    assign exec    = slot_grant && busy && (slot_col >= min_col);
    assign mem_we  = exec && (pend_q == ACC_WRITE) && !pal_sel;
    assign pal_we  = exec && (pend_q == ACC_WRITE) && pal_sel;
    assign mem_re  = exec && (pend_q == ACC_READ);
    assign pal_idx = ptr_q[PI_W-1:0];

    // Update the single pending access; a new host request wins
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= ACC_NONE;
        else if (data_wr) pend_q <= ACC_WRITE;
        else if (data_rd) pend_q <= ACC_READ;
        else if (addr_ld) pend_q <= addr_rdq ? ACC_READ : ACC_NONE;
        else if (exec)    pend_q <= ACC_NONE;
    end

    // Load or step the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (addr_ld) ptr_q <= addr_val;
        else if (exec)    ptr_q <= ptr_q + 1'b1;
    end

    // Fill the read-ahead buffer from the host or from memory
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_q <= 8'h00;
        else if (data_wr) buf_q <= din;
        else if (mem_re)  buf_q <= mem_rdata;
    end

    // R5
    col_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_col < min_col) |-> !(mem_we || mem_re || pal_we));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re || pal_we) && !addr_ld) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re, pal_we}));

    // R8
    pal_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_sel |-> !mem_we);

endmodule

// File: rtl/vhp_palette.sv
// Colour palette storage.
// Each write widens a 6-bit code to 24-bit RGB. The read port is
// combinational. Assumes the write data carries the code in bits 5:0.
module vhp_palette
    import vhp_pkg::*;
#(
    parameter int PI_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [PI_W-1:0] wr_idx,
    input  logic [7:0]      wr_code,
    input  logic [PI_W-1:0] rd_idx,
    output logic [23:0]     rd_rgb
);
    localparam int ENTRIES = 1 << PI_W;

    logic [23:0] ent [ENTRIES];
    logic [23:0] widened;

    assign widened = widen_colour(wr_code[5:0]);
    assign rd_rgb  = ent[rd_idx];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Store the widened colour into entry i
        always_ff @(posedge clk) begin
            if (!rst_n)                     ent[i] <= 24'h0;
            else if (wr && wr_idx == PI_W'(i)) ent[i] <= widened;
        end
    end

    // R9
    red_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rd_idx == wr_idx) |=> (rd_rgb[23:16] == 8'($past(wr_code[1:0])) * 8'd85));

endmodule

// File: rtl/vram_host_port.sv
// Host-side access port of a video controller.
// Splits host strobes into control-port and data-port actions. Holds the
// registered read data. Connects the pairing logic, the access engine and
// the palette. Assumes cpu_wr and cpu_rd are never high together.
module vram_host_port #(
    parameter int AW    = 14,
    parameter int COL_W = 9,
    parameter int RW    = 4,
    parameter int PI_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             pal_sel,
    output logic             reg_we,
    output logic [RW-1:0]    reg_idx,
    output logic [7:0]       reg_val,
    output logic             mem_req,
    input  logic             slot_grant,
    input  logic [COL_W-1:0] slot_col,
    input  logic [COL_W-1:0] min_col,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    output logic             mem_re,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata,
    input  logic [PI_W-1:0]  pal_rd_idx,
    output logic [23:0]      pal_rd_rgb
);
    logic            data_wr, data_rd, ctrl_wr, ctrl_rd, phase_clr;
    logic            addr_ld, addr_rdq, pal_we;
    logic [AW-1:0]   addr_val;
    logic [7:0]      buf_q;
    logic [PI_W-1:0] pal_idx;

    assign data_wr   = cpu_wr && !cpu_sel;
    assign data_rd   = cpu_rd && !cpu_sel;
    assign ctrl_wr   = cpu_wr && cpu_sel;
    assign ctrl_rd   = cpu_rd && cpu_sel;
    assign phase_clr = data_wr || data_rd || ctrl_rd;
    assign mem_wdata = buf_q;

    // Return the buffer on data reads and zero on control reads
    always_ff @(posedge clk) begin
        if (!rst_n)       cpu_rdata <= 8'h00;
        else if (data_rd) cpu_rdata <= buf_q;
        else if (ctrl_rd) cpu_rdata <= 8'h00;
    end

    vhp_ctrl_seq #(.AW(AW), .RW(RW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .phase_clr (phase_clr),
        .din       (cpu_wdata),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_val   (reg_val),
        .addr_ld   (addr_ld),
        .addr_val  (addr_val),
        .addr_rdq  (addr_rdq)
    );

    vhp_access_engine #(.AW(AW), .COL_W(COL_W), .PI_W(PI_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .din        (cpu_wdata),
        .addr_ld    (addr_ld),
        .addr_val   (addr_val),
        .addr_rdq   (addr_rdq),
        .slot_grant (slot_grant),
        .slot_col   (slot_col),
        .min_col    (min_col),
        .pal_sel    (pal_sel),
        .mem_rdata  (mem_rdata),
        .buf_q      (buf_q),
        .ptr_q      (mem_addr),
        .busy       (mem_req),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .pal_we     (pal_we),
        .pal_idx    (pal_idx)
    );

    vhp_palette #(.PI_W(PI_W)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (pal_we),
        .wr_idx  (pal_idx),
        .wr_code (buf_q),
        .rd_idx  (pal_rd_idx),
        .rd_rgb  (pal_rd_rgb)
    );

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd) |=> $stable(cpu_rdata));

endmodule

// File: tb/vram_host_port_test.sv
`timescale 1ns/1ps
module vram_host_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        pal_sel = 1'b0;
    logic        reg_we;
    logic [3:0]  reg_idx;
    logic [7:0]  reg_val;
    logic        mem_req;
    logic        slot_grant = 1'b0;
    logic [8:0]  slot_col = 9'd0, min_col = 9'd10;
    logic [13:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [4:0]  pal_rd_idx = 5'd0;
    logic [23:0] pal_rd_rgb;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] mem [256];
    logic s_we, s_re;
    logic [13:0] s_addr;
    logic [7:0]  s_wdata;

    always #2 clk = ~clk;

    vram_host_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pal_sel(pal_sel),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val), .mem_req(mem_req),
        .slot_grant(slot_grant), .slot_col(slot_col), .min_col(min_col),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pal_rd_idx(pal_rd_idx), .pal_rd_rgb(pal_rd_rgb)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic slot(input logic [8:0] col);
        @(negedge clk);
        slot_grant = 1'b1; slot_col = col;
        #1;
        s_we = mem_we; s_re = mem_re; s_addr = mem_addr; s_wdata = mem_wdata;
        @(negedge clk);
        slot_grant = 1'b0;
    endtask

    function automatic logic [23:0] colour(input int c);
        int r, g, b;
        r = (c & 3) * 85;
        g = ((c >> 2) & 3) * 85;
        case ((c >> 4) & 3)
            0: b = 0;
            1: b = 104;
            2: b = 170;
            default: b = 255;
        endcase
        return {r[7:0], g[7:0], b[7:0]};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_req == 0 && reg_we == 0 && cpu_rdata == 0, "R1", {mem_req, reg_we, cpu_rdata}, 0);
        check(mem_addr == 0, "R1 pointer", mem_addr, 0);

        // R2 register writes for every index
        for (int i = 0; i < 16; i++) begin
            cpu_op(1, 1, 0, 8'(i * 13 + 1));
            check(reg_we == 0, "R2 first byte", reg_we, 0);
            cpu_op(1, 1, 0, 8'h80 | 8'(i));
            check(reg_we == 1 && reg_idx == 4'(i) && reg_val == 8'(i * 13 + 1), "R2",
                  {reg_we, reg_idx, reg_val}, {1'b1, 4'(i), 8'(i * 13 + 1)});
            check(mem_addr == 0, "R2 pointer kept", mem_addr, 0);
        end

        // R3 write-mode address at the top of memory
        cpu_op(1, 1, 0, 8'hFF);
        cpu_op(1, 1, 0, 8'h7F);
        check(mem_addr == 14'h3FFF && mem_req == 0, "R3", {mem_req, mem_addr}, 14'h3FFF);
        cpu_op(0, 1, 0, 8'hA5);
        check(mem_req == 1, "R4 pending", mem_req, 1);
        // R5 slot below minimum column
        slot(9'd5);
        check(s_we == 0 && s_re == 0 && mem_req == 1, "R5", {s_we, s_re, mem_req}, 1);
        slot(9'd10);
        check(s_we == 1 && s_addr == 14'h3FFF && s_wdata == 8'hA5, "R4", {s_we, s_addr, s_wdata},
              {1'b1, 14'h3FFF, 8'hA5});
        // R10 wrap
        check(mem_addr == 0 && mem_req == 0, "R10", {mem_req, mem_addr}, 0);

        // R4 write sweep from 0x1230
        cpu_op(1, 1, 0, 8'h30);
        cpu_op(1, 1, 0, 8'h52);
        for (int i = 0; i < 16; i++) begin
            cpu_op(0, 1, 0, 8'(8'hC0 ^ i));
            slot(9'(100 + i));
            check(s_we == 1 && s_addr == 14'h1230 + 14'(i), "R4 sweep", s_addr, 14'h1230 + 14'(i));
            check(mem[8'h30 + 8'(i)] == 8'(8'hC0 ^ i), "R4 data", mem[8'h30 + 8'(i)], 8'(8'hC0 ^ i));
        end

        // R6 read-mode address queues a read
        cpu_op(1, 1, 0, 8'h30);
        cpu_op(1, 1, 0, 8'h12);
        check(mem_req == 1 && mem_addr == 14'h1230, "R3 read queued", {mem_req, mem_addr}, {1'b1, 14'h1230});
        slot(9'd20);
        check(s_re == 1 && mem_addr == 14'h1231, "R6 exec", {s_re, mem_addr}, {1'b1, 14'h1231});
        for (int i = 0; i < 15; i++) begin
            cpu_op(0, 0, 1, 8'h00);
            check(cpu_rdata == 8'(8'hC0 ^ i), "R6 data", cpu_rdata, 8'(8'hC0 ^ i));
            slot(9'd30);
        end

        // R7 stray first byte then data read
        cpu_op(1, 1, 0, 8'h05);
        cpu_op(0, 0, 1, 8'h00);
        cpu_op(1, 1, 0, 8'h03);
        cpu_op(1, 1, 0, 8'h87);
        check(reg_we == 1 && reg_idx == 7 && reg_val == 8'h03, "R7 data", {reg_idx, reg_val}, {4'd7, 8'h03});
        // R7 stray first byte then control read
        cpu_op(1, 1, 0, 8'h09);
        cpu_op(1, 0, 1, 8'h00);
        cpu_op(1, 1, 0, 8'h44);
        cpu_op(1, 1, 0, 8'h82);
        check(reg_we == 1 && reg_idx == 2 && reg_val == 8'h44, "R7 ctrl", {reg_idx, reg_val}, {4'd2, 8'h44});

        // R11 second write replaces first
        cpu_op(1, 1, 0, 8'h80);
        cpu_op(1, 1, 0, 8'h40);
        cpu_op(0, 1, 0, 8'h11);
        cpu_op(0, 1, 0, 8'h22);
        slot(9'd50);
        check(s_we == 1 && s_wdata == 8'h22 && s_addr == 14'h0080, "R11", {s_addr, s_wdata}, {14'h0080, 8'h22});
        slot(9'd51);
        check(s_we == 0 && mem_req == 0, "R11 single", {s_we, mem_req}, 0);

        // R8 and R9 palette sweep over all codes
        pal_sel = 1'b1;
        cpu_op(1, 1, 0, 8'h00);
        cpu_op(1, 1, 0, 8'h40);
        for (int v = 0; v < 64; v++) begin
            cpu_op(0, 1, 0, 8'(v));
            slot(9'd200);
            check(s_we == 0 && mem_addr == 14'(v + 1), "R8", {s_we, mem_addr}, 14'(v + 1));
            pal_rd_idx = 5'(v);
            #1;
            check(pal_rd_rgb == colour(v), "R9", pal_rd_rgb, colour(v));
        end
        for (int i = 0; i < 32; i++) begin
            pal_rd_idx = 5'(i);
            #1;
            check(pal_rd_rgb == colour(i + 32), "R9 final", pal_rd_rgb, colour(i + 32));
        end
        pal_sel = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule